// File: doc/BRIEF.md
# Dual-Channel Cosine Waveform Generator

This block synthesizes a digital cosine for two 8-bit converter channels from one shared phase accumulator. Every clock the accumulator advances by a programmable step, so the output frequency equals the clock rate times the step divided by 2^16. The top bits of the phase select a quadrant and an index into a 64-entry quarter-wave table. Symmetry folding rebuilds the other three quadrants.

Each channel shapes the shared signed wave on its own terms. It applies a binary attenuation, an optional polarity inversion and a signed DC offset. The result is centred on mid-scale and clipped to an unsigned code. Channels are started and stopped independently with single-cycle pulses. A redundant request raises a one-cycle error flag. An idle channel holds its offset-adjusted mid-scale level.

Top module: `cosgen_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every `code_o` lane reads 128, and `running_o` and `err_o` are all 0.
- R2: For a running channel, the wave value is taken from the accumulator. Bits [15:14] are the quadrant q and bits [13:8] are the index i. With L[k] = floor(127*(65536-4u^2)/(65536+u^2)) and u = 2k+1, the wave is +L[i] for q=0, -L[63-i] for q=1, -L[i] for q=2 and +L[63-i] for q=3.
- R3: The 16-bit accumulator is shared by both channels. It adds `step_i` modulo 2^16 on every clock edge where at least one channel was running before the edge. On any edge where no channel was running, it loads 0.
- R4: The 2-bit attenuation field of a channel divides the wave by an arithmetic right shift of 0, 1, 2 or 3 bits for the codes 0 to 3.
- R5: The 2-bit phase field code 01 negates the attenuated wave. The codes 00, 10 and 11 all leave it unchanged.
- R6: The code of a running channel is 128 plus the shaped wave plus the channel's two's-complement 8-bit offset, clipped to the range 0 to 255.
- R7: A stopped channel outputs 128 plus its offset, clipped to the range 0 to 255.
- R8: A start pulse sets the channel's `running_o` at the next edge and a stop pulse clears it. When both pulses arrive together, stop wins.
- R9: `err_o` of a channel pulses for one cycle after the edge that saw a start while the channel was running, or a stop while it was stopped.
- R10: `code_o` is registered. It reflects the accumulator, run state and configuration present just before the clock edge that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Generator clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| step_i | input | 16 | Phase increment per clock, shared by all channels |
| start_i | input | 2 | Per-channel start pulse |
| stop_i | input | 2 | Per-channel stop pulse |
| atten_i | input | 4 | Per-channel attenuation code, 2 bits per lane |
| phase_i | input | 4 | Per-channel phase code, 2 bits per lane |
| offset_i | input | 16 | Per-channel signed DC offset, 8 bits per lane |
| code_o | output | 16 | Per-channel unsigned output code, 8 bits per lane |
| running_o | output | 2 | Per-channel run state |
| err_o | output | 2 | Per-channel redundant-request flag |

## Verification
Every result here is due exactly one clock edge after its cause. The code, run state and error flag each come from a single register. The accumulator feeding the code reflects the run state of the previous edge, so a fresh start first shows phase zero on the second edge. The bench drives inputs one time unit after an edge. Just before each edge it advances its own arithmetic model of accumulator, run state and expected outputs, then compares every output one time unit after that edge. The sweep covers all attenuation and phase codes, all 256 idle offsets, saturation at both rails, a step change mid-run and redundant start and stop requests.

// File: rtl/cosgen_pkg.sv
package cosgen_pkg;

   // phase field code that selects the inverted polarity
   localparam logic [1:0] PH_INVERT = 2'b01;

   // rational cosine approximation sampled at quarter-wave bin midpoints
   function automatic int quarter_sample(int k, int idx_w, int dw);
      longint q;
      longint d;
      longint u;
      longint a;
      q = longint'(1) << idx_w;
      d = 16 * q * q;
      u = 2 * k + 1;
      a = (longint'(1) << (dw - 1)) - 1;
      return int'((a * (d - 4 * u * u)) / (d + u * u));
   endfunction

endpackage

// File: rtl/cosgen_phase_acc.sv
module cosgen_phase_acc #(
   parameter int ACC_W = 16,
   parameter int IDX_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             advance_i,
   input  logic [ACC_W-1:0] step_i,
   output logic [1:0]       quad_o,
   output logic [IDX_W-1:0] idx_o
);
   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)         acc_q <= '0;
      else if (!advance_i) acc_q <= '0;
      else                 acc_q <= acc_q + step_i;
   end

   assign quad_o = acc_q[ACC_W-1 -: 2];
   assign idx_o  = acc_q[ACC_W-3 -: IDX_W];
endmodule

// File: rtl/cosgen_quarter_rom.sv
module cosgen_quarter_rom #(
   parameter int IDX_W = 6,
   parameter int DW    = 8
) (
   input  logic [1:0]           quad_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic signed [DW-1:0] wave_o
);
   localparam int DEPTH = 1 << IDX_W;

   logic [DW-2:0]    tbl [DEPTH];
   logic [IDX_W-1:0] addr;
   logic [DW-1:0]    mag;

   for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
      localparam int V = cosgen_pkg::quarter_sample(k, IDX_W, DW);
      assign tbl[k] = V[DW-2:0];
   end

   // odd quadrants read the table mirrored, the middle two are negative
   assign addr = quad_i[0] ? ~idx_i : idx_i;
   assign mag  = {1'b0, tbl[addr]};

   always_comb begin
      if (quad_i[1] ^ quad_i[0]) wave_o = -$signed(mag);
      else                       wave_o = $signed(mag);
   end
endmodule

// File: rtl/cosgen_chan.sv
module cosgen_chan #(
   parameter int DW = 8
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic                 stop_i,
   input  logic [1:0]           atten_i,
   input  logic [1:0]           phase_i,
   input  logic signed [DW-1:0] offset_i,
   input  logic signed [DW-1:0] wave_i,
   output logic [DW-1:0]        code_o,
   output logic                 running_o,
   output logic                 err_o
);
   localparam int SW = DW + 2;
   localparam logic signed [SW-1:0] MIDX = SW'(1 << (DW - 1));
   localparam logic signed [SW-1:0] MAXX = SW'((1 << DW) - 1);

   logic                 run_q;
   logic                 err_q;
   logic [DW-1:0]        code_q;
   logic signed [DW-1:0] shifted;
   logic signed [DW-1:0] shaped;
   logic signed [SW-1:0] sum;
   logic [DW-1:0]        code_d;

   always_comb begin
      shifted = wave_i >>> atten_i;
      if (!run_q)                              shaped = '0;
      else if (phase_i == cosgen_pkg::PH_INVERT) shaped = -shifted;
      else                                     shaped = shifted;
      sum = MIDX + {{2{shaped[DW-1]}}, shaped} + {{2{offset_i[DW-1]}}, offset_i};
      if (sum < 0)         code_d = '0;
      else if (sum > MAXX) code_d = '1;
      else                 code_d = sum[DW-1:0];
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q  <= 1'b0;
         err_q  <= 1'b0;
         code_q <= MIDX[DW-1:0];
      end else begin
         err_q  <= (start_i & run_q) | (stop_i & ~run_q);
         code_q <= code_d;
         if (stop_i)       run_q <= 1'b0;
         else if (start_i) run_q <= 1'b1;
      end
   end

   assign code_o    = code_q;
   assign running_o = run_q;
   assign err_o     = err_q;
endmodule

// File: rtl/cosgen_top.sv
module cosgen_top #(
   parameter int ACC_W = 16,
   parameter int IDX_W = 6,
   parameter int DW    = 8,
   parameter int NCH   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ACC_W-1:0]  step_i,
   input  logic [NCH-1:0]    start_i,
   input  logic [NCH-1:0]    stop_i,
   input  logic [2*NCH-1:0]  atten_i,
   input  logic [2*NCH-1:0]  phase_i,
   input  logic [DW*NCH-1:0] offset_i,
   output logic [DW*NCH-1:0] code_o,
   output logic [NCH-1:0]    running_o,
   output logic [NCH-1:0]    err_o
);
   if (ACC_W < IDX_W + 2) begin : g_bad_acc
      $error("accumulator narrower than quadrant plus index");
   end
   if (DW < 4) begin : g_bad_dw
      $error("output width below 4 bits");
   end
   if (NCH < 1) begin : g_bad_nch
      $error("at least one channel required");
   end

   logic [1:0]           quad;
   logic [IDX_W-1:0]     idx;
   logic signed [DW-1:0] wave;
   logic [NCH-1:0]       running;

   cosgen_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .advance_i (|running),
      .step_i    (step_i),
      .quad_o    (quad),
      .idx_o     (idx)
   );

   cosgen_quarter_rom #(.IDX_W(IDX_W), .DW(DW)) u_rom (
      .quad_i (quad),
      .idx_i  (idx),
      .wave_o (wave)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      cosgen_chan #(.DW(DW)) u_chan (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .start_i   (start_i[c]),
         .stop_i    (stop_i[c]),
         .atten_i   (atten_i[2*c +: 2]),
         .phase_i   (phase_i[2*c +: 2]),
         .offset_i  ($signed(offset_i[DW*c +: DW])),
         .wave_i    (wave),
         .code_o    (code_o[DW*c +: DW]),
         .running_o (running[c]),
         .err_o     (err_o[c])
      );
   end

   assign running_o = running;
endmodule

// File: rtl/cosgen_top_chk.sv
module cosgen_top_chk #(
   parameter int ACC_W = 16,
   parameter int DW    = 8,
   parameter int NCH   = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ACC_W-1:0]  step_i,
   input logic [NCH-1:0]    start_i,
   input logic [NCH-1:0]    stop_i,
   input logic [DW*NCH-1:0] offset_i,
   input logic [DW*NCH-1:0] code_o,
   input logic [NCH-1:0]    running_o,
   input logic [NCH-1:0]    err_o
);
   logic rdy_q;
   always_ff @(posedge clk_i) rdy_q <= rst_ni;

   function automatic logic [DW-1:0] idle_code(logic [DW-1:0] off);
      int v;
      v = (1 << (DW - 1)) + int'($signed(off));
      if (v < 0) return '0;
      if (v > (1 << DW) - 1) return '1;
      return v[DW-1:0];
   endfunction

   for (genvar c = 0; c < NCH; c++) begin : g_prop
      assert_start_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (start_i[c] && !stop_i[c]) |=> running_o[c]);
      assert_stop_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         stop_i[c] |=> !running_o[c]);
      assert_err_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rdy_q && err_o[c]) |-> ($past(start_i[c]) || $past(stop_i[c])));
      assert_dup_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (start_i[c] && !stop_i[c] && running_o[c]) |=> err_o[c]);
      assert_idle_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (rdy_q && $past(rdy_q) && $past(!running_o[c]))
         |-> code_o[DW*c +: DW] == idle_code($past(offset_i[DW*c +: DW])));
   end
endmodule

bind cosgen_top cosgen_top_chk #(.ACC_W(ACC_W), .DW(DW), .NCH(NCH)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .step_i    (step_i),
   .start_i   (start_i),
   .stop_i    (stop_i),
   .offset_i  (offset_i),
   .code_o    (code_o),
   .running_o (running_o),
   .err_o     (err_o)
);

// File: tb/cosgen_top_bench.sv
module cosgen_top_bench;
   localparam int ACC_W = 16;
   localparam int DW    = 8;
   localparam int NCH   = 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [ACC_W-1:0] step = '0;
   logic [1:0]       start = '0;
   logic [1:0]       stop = '0;
   logic [1:0]       att [2];
   logic [1:0]       ph [2];
   logic [7:0]       off [2];
   logic [15:0]      code;
   logic [1:0]       running;
   logic [1:0]       err;

   int n_chk = 0;
   int n_bad = 0;
   int m_acc = 0;
   bit m_run [2];
   int e_code [2];
   bit e_err [2];

   always #4 clk = ~clk;

   cosgen_top u_cosgen_top (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .step_i    (step),
      .start_i   (start),
      .stop_i    (stop),
      .atten_i   ({att[1], att[0]}),
      .phase_i   ({ph[1], ph[0]}),
      .offset_i  ({off[1], off[0]}),
      .code_o    (code),
      .running_o (running),
      .err_o     (err)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int lut(int k);
      int u;
      u = 2 * k + 1;
      return (127 * (65536 - 4 * u * u)) / (65536 + u * u);
   endfunction

   function automatic int wave_of(int acc);
      int q;
      int i;
      q = (acc >> 14) & 3;
      i = (acc >> 8) & 63;
      case (q)
         0: return lut(i);
         1: return -lut(63 - i);
         2: return -lut(i);
         default: return lut(63 - i);
      endcase
   endfunction

   function automatic int shape(int acc, int a, int p, int o, bit run);
      int s;
      int v;
      s = 0;
      if (run) begin
         s = wave_of(acc) >>> a;
         if (p == 1) s = -s;
      end
      v = 128 + s + o;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      return v;
   endfunction

   task automatic tick(string tag);
      int  nc [2];
      bit  ne [2];
      bit  nr [2];
      int  nacc;
      for (int c = 0; c < 2; c++) begin
         nc[c] = shape(m_acc, int'(att[c]), int'(ph[c]), int'($signed(off[c])), m_run[c]);
         ne[c] = (start[c] && m_run[c]) || (stop[c] && !m_run[c]);
         nr[c] = stop[c] ? 1'b0 : (start[c] ? 1'b1 : m_run[c]);
      end
      nacc = (m_run[0] || m_run[1]) ? ((m_acc + int'(step)) & 16'hFFFF) : 0;
      @(posedge clk);
      #1;
      m_acc = nacc;
      start = '0;
      stop  = '0;
      for (int c = 0; c < 2; c++) begin
         m_run[c]  = nr[c];
         e_code[c] = nc[c];
         e_err[c]  = ne[c];
         chk(int'(code[8*c +: 8]) == nc[c], tag, int'(code[8*c +: 8]), nc[c]);
         chk(running[c] == nr[c], "R8 run state", int'(running[c]), int'(nr[c]));
         chk(err[c] == ne[c], "R9 error flag", int'(err[c]), int'(ne[c]));
      end
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int c = 0; c < 2; c++) begin
         att[c] = '0; ph[c] = '0; off[c] = '0; m_run[c] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #1;
      for (int c = 0; c < 2; c++) begin
         chk(code[8*c +: 8] == 8'd128, "R1 reset code", int'(code[8*c +: 8]), 128);
         chk(running[c] == 1'b0, "R1 reset run", int'(running[c]), 0);
         chk(err[c] == 1'b0, "R1 reset err", int'(err[c]), 0);
      end
      rst_n = 1'b1;
      tick("R1 first code");

      // R7: every idle offset on both lanes
      for (int o = -128; o < 128; o++) begin
         off[0] = 8'(o);
         off[1] = 8'(-1 - o);
         tick("R7 idle level");
      end

      // R2 R3 R4 R5 R10: one full period per attenuation/phase pairing
      step = 16'd256;
      off[0] = '0;
      off[1] = 8'(-20);
      start = 2'b11;
      tick("R8 start");
      for (int a = 0; a < 4; a++) begin
         for (int p = 0; p < 4; p++) begin
            att[0] = 2'(a); ph[0] = 2'(p);
            att[1] = 2'(3 - a); ph[1] = 2'(3 - p);
            for (int n = 0; n < 256; n++) tick("R2 R3 R4 R5 R10 wave");
         end
      end

      // R6: clip at both rails
      att[0] = 2'd0; ph[0] = 2'd0; off[0] = 8'sd127;
      att[1] = 2'd0; ph[1] = 2'd1; off[1] = 8'h80;
      for (int n = 0; n < 256; n++) tick("R6 saturation");

      // R9: redundant start on a running lane, then double stop
      start = 2'b01;
      tick("R9 dup start");
      stop = 2'b10;
      tick("R9 stop");
      stop = 2'b10;
      tick("R9 dup stop");
      start = 2'b10;
      stop  = 2'b10;
      tick("R8 stop wins");

      // R3: shared step change while running
      off[0] = 8'sd5;
      att[0] = 2'd1;
      step = 16'd1000;
      for (int n = 0; n < 300; n++) tick("R3 step a");
      step = 16'd77;
      start = 2'b10;
      for (int n = 0; n < 300; n++) tick("R3 step b");

      // R3: both stopped clears phase, restart begins at peak
      stop = 2'b11;
      tick("R8 stop all");
      tick("R3 idle");
      att[0] = 2'd0; ph[0] = 2'd0; off[0] = '0;
      start = 2'b01;
      tick("R8 restart");
      tick("R3 restart peak");
      chk(code[7:0] == 8'd254, "R3 restart peak", int'(code[7:0]), 254);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule